// File: doc/BRIEF.md
# Tagged Receive Silo With Alarm

This block collects characters from sixteen serial receive lines into one shared first-in first-out store. Each store entry carries the character, the line it arrived on, and three error flags: parity, framing (a received break) and data overrun. The host removes entries one at a time through a pop strobe. The popped word has its top bit set when a character was present, so driver code can keep popping until the word reads as a non-negative 16-bit value.

Every line has a one-character holding slot. A fixed-priority arbiter moves one slot per cycle into the store, always taking the lowest line number first. A character is lost in two cases: it arrives while its line's slot is still occupied, or its slot is granted while the store is full. In both cases the next character stored from that line carries the overrun flag. A host-programmed alarm level sets a receive flag once the fill level reaches it. A receive interrupt is raised only while that flag and its enable are both set.

Top module: `tagged_rx_silo`

## Requirements
- R1: After reset the store is empty, rx_word is 0x0000, csr_rdata is 0x0000, rx_irq is low, and alarm_rdata reads 1.
- R2: A popped entry reads as follows. Bit 15 is 1. Bits 11:8 hold the line number and bits 7:0 the character. Bit 12 is the parity error flag and bit 13 the framing error flag. Entries pop oldest first, and rx_word holds its value until the next pop.
- R3: A pop while the store is empty returns 0x0000, with bit 15 clear.
- R4: When several lines push in the same cycle, their characters are stored one per cycle, lowest line number first.
- R5: A push to a line whose holding slot is still occupied is discarded. The next character stored from that line has bit 14 (overrun) set, and the characters after it have bit 14 clear.
- R6: The store holds 64 entries. A character granted while the store is full is discarded, and the next character stored from that line has bit 14 set.
- R7: A pop and a store in the same cycle are both carried out, and entry order is kept.
- R8: The receive flag is csr_rdata bit 7. It is 1 exactly when the fill level is non-zero and at least the alarm level. It follows the fill level one cycle later.
- R9: csr_wdata bit 6, written with csr_we, sets the interrupt enable, which reads back at csr_rdata bit 6. rx_irq is high only while the flag and the enable are both 1.
- R10: The alarm level is written through alarm_we and alarm_wdata and reads back on alarm_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_push | input | 16 | Per-line strobe: a character is complete |
| line_char | input | 128 | Per-line character, 8 bits per line, line 0 in the low byte |
| line_perr | input | 16 | Per-line parity error for the pushed character |
| line_ferr | input | 16 | Per-line framing error for the pushed character |
| rx_pop | input | 1 | Pop one entry from the store |
| rx_word | output | 16 | Tagged word from the last pop |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 16 | Control write data, bit 6 is the interrupt enable |
| csr_rdata | output | 16 | Status: bit 7 receive flag, bit 6 interrupt enable |
| alarm_we | input | 1 | Write strobe for the alarm level |
| alarm_wdata | input | 7 | New alarm level |
| alarm_rdata | output | 7 | Current alarm level |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A push captured at edge k fills its line's slot at k. If no lower line is waiting, it is stored at k+1 and counts toward the fill level from k+1. The flag and interrupt follow at k+2, and each extra waiting lower line delays this by one cycle. A pop at edge p updates rx_word at p, and the flag reflects the lowered level at p+1. The bench drives inputs on falling edges and waits at least two cycles after the last push before it pops or compares. Flag and interrupt checks are sampled at the falling edge just before and just after the cycle in which they are due.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int PRESENT_BIT = 15;
  localparam int OVR_BIT     = 14;
  localparam int FERR_BIT    = 13;
  localparam int PERR_BIT    = 12;
  localparam int CSR_FLAG_BIT = 7;
  localparam int CSR_IE_BIT   = 6;
endpackage

// File: rtl/rxs_line_hold.sv
module rxs_line_hold #(
  parameter int CHAR_W = 8,
  localparam int ENT_W = CHAR_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              grant_i,
  input  logic              drop_i,
  output logic              valid_o,
  output logic [ENT_W-1:0]  entry_o
);
  logic              valid_q;
  logic              ovr_q;
  logic              perr_q;
  logic              ferr_q;
  logic [CHAR_W-1:0] char_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      char_q  <= '0;
    end else if (grant_i) begin
      ovr_q   <= drop_i;
      valid_q <= push_i;
      if (push_i) begin
        char_q <= char_i;
        perr_q <= perr_i;
        ferr_q <= ferr_i;
      end
    end else if (push_i) begin
      if (valid_q) begin
        ovr_q <= 1'b1;
      end else begin
        valid_q <= 1'b1;
        char_q  <= char_i;
        perr_q  <= perr_i;
        ferr_q  <= ferr_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign entry_o = {ovr_q, ferr_q, perr_q, char_q};
endmodule

// File: rtl/rxs_arbiter.sv
module rxs_arbiter #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 15,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_hit_o,
  output logic              accept_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_hit_q;
  logic              rd_ok;
  logic              wr_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign rd_ok = rd_i && (count_q != '0);
  assign wr_ok = wr_i && ((count_q < CNT_W'(DEPTH)) || rd_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wdata_i;
    if (rd_ok) rdata_q <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      rd_hit_q <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (rd_i)  rd_hit_q <= rd_ok;
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata_o  = rdata_q;
  assign rd_hit_o = rd_hit_q;
  assign accept_o = wr_ok;
  assign count_o  = count_q;
endmodule

// File: rtl/tagged_rx_silo.sv
module tagged_rx_silo #(
  parameter int NUM_LINES = 16,
  parameter int CHAR_W    = 8,
  parameter int DEPTH     = 64,
  parameter int ALARM_RST = 1,
  localparam int LINE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int ENT_W   = CHAR_W + 3,
  localparam int DATA_W  = ENT_W + LINE_W,
  localparam int WORD_W  = DATA_W + 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int ALARM_W = CNT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        line_push,
  input  logic [NUM_LINES*CHAR_W-1:0] line_char,
  input  logic [NUM_LINES-1:0]        line_perr,
  input  logic [NUM_LINES-1:0]        line_ferr,
  input  logic                        rx_pop,
  output logic [WORD_W-1:0]           rx_word,
  input  logic                        csr_we,
  input  logic [15:0]                 csr_wdata,
  output logic [15:0]                 csr_rdata,
  input  logic                        alarm_we,
  input  logic [ALARM_W-1:0]          alarm_wdata,
  output logic [ALARM_W-1:0]          alarm_rdata,
  output logic                        rx_irq
);
  import rxs_pkg::*;

  logic [NUM_LINES-1:0] hold_valid;
  logic [ENT_W-1:0]     hold_entry [NUM_LINES];
  logic [NUM_LINES-1:0] grant;
  logic [LINE_W-1:0]    grant_idx;
  logic                 grant_any;
  logic                 store_ok;
  logic                 store_drop;
  logic [ENT_W-1:0]     sel_entry;
  logic [DATA_W-1:0]    store_word;
  logic [DATA_W-1:0]    fifo_rdata;
  logic                 fifo_hit;
  logic [CNT_W-1:0]     fifo_count;

  logic                 ie_q;
  logic                 flag_q;
  logic                 irq_q;
  logic [ALARM_W-1:0]   alarm_q;
  logic                 flag_d;
  logic                 unused_csr;

  assign unused_csr = ^{csr_wdata[15:CSR_IE_BIT+1], csr_wdata[CSR_IE_BIT-1:0]};

  assign store_drop = grant_any && !store_ok;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    rxs_line_hold #(.CHAR_W(CHAR_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .push_i  (line_push[g]),
      .char_i  (line_char[g*CHAR_W +: CHAR_W]),
      .perr_i  (line_perr[g]),
      .ferr_i  (line_ferr[g]),
      .grant_i (grant[g]),
      .drop_i  (store_drop),
      .valid_o (hold_valid[g]),
      .entry_o (hold_entry[g])
    );
  end

  rxs_arbiter #(.N(NUM_LINES)) u_arb (
    .req_i   (hold_valid),
    .grant_o (grant),
    .idx_o   (grant_idx),
    .any_o   (grant_any)
  );

  assign sel_entry  = hold_entry[grant_idx];
  assign store_word = {sel_entry[ENT_W-1 -: 3], grant_idx, sel_entry[CHAR_W-1:0]};

  rxs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (grant_any),
    .wdata_i  (store_word),
    .rd_i     (rx_pop),
    .rdata_o  (fifo_rdata),
    .rd_hit_o (fifo_hit),
    .accept_o (store_ok),
    .count_o  (fifo_count)
  );

  assign flag_d = (fifo_count != '0) && (fifo_count >= alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      alarm_q <= ALARM_W'(ALARM_RST);
    end else begin
      if (csr_we)   ie_q    <= csr_wdata[CSR_IE_BIT];
      if (alarm_we) alarm_q <= alarm_wdata;
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_q;
    end
  end

  assign rx_word = fifo_hit ? {1'b1, fifo_rdata} : '0;

  always_comb begin
    csr_rdata = '0;
    csr_rdata[CSR_FLAG_BIT] = flag_q;
    csr_rdata[CSR_IE_BIT]   = ie_q;
  end

  assign alarm_rdata = alarm_q;
  assign rx_irq      = irq_q;
endmodule

// File: rtl/tagged_rx_silo_chk.sv
module tagged_rx_silo_chk #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_pop,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_irq,
  input logic              ie_q,
  input logic              flag_q,
  input logic [CNT_W-1:0]  fill
);
  AST_EMPTY_POP_BLANK: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && fill == '0) |=> !rx_word[WORD_W-1]); // R3
  AST_POP_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && fill != '0) |=> rx_word[WORD_W-1]); // R2
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !rx_pop |=> $stable(rx_word)); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH)); // R6
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
             (fill + 1'b1 == $past(fill))); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> ($past(ie_q) && flag_q)); // R9
  AST_FLAG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && $past(fill) == '0) |-> !flag_q); // R8
endmodule

bind tagged_rx_silo tagged_rx_silo_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rx_pop  (rx_pop),
  .rx_word (rx_word),
  .rx_irq  (rx_irq),
  .ie_q    (ie_q),
  .flag_q  (flag_q),
  .fill    (fifo_count)
);

// File: tb/tagged_rx_silo_bench.sv
`timescale 1ns/100ps
module tagged_rx_silo_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [15:0]  line_push;
  logic [127:0] line_char;
  logic [15:0]  line_perr;
  logic [15:0]  line_ferr;
  logic         rx_pop;
  logic [15:0]  rx_word;
  logic         csr_we;
  logic [15:0]  csr_wdata;
  logic [15:0]  csr_rdata;
  logic         alarm_we;
  logic [6:0]   alarm_wdata;
  logic [6:0]   alarm_rdata;
  logic         rx_irq;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  tagged_rx_silo u_tagged_rx_silo (
    .clk, .rst, .line_push, .line_char, .line_perr, .line_ferr,
    .rx_pop, .rx_word, .csr_we, .csr_wdata, .csr_rdata,
    .alarm_we, .alarm_wdata, .alarm_rdata, .rx_irq
  );

  function automatic logic [15:0] mk(input int ln, input logic [7:0] ch,
                                     input logic pe, input logic fe, input logic ov);
    return {1'b1, ov, fe, pe, 4'(ln), ch};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push1(input int ln, input logic [7:0] ch, input logic pe, input logic fe);
    line_push[ln] = 1'b1;
    line_char[ln*8 +: 8] = ch;
    line_perr[ln] = pe;
    line_ferr[ln] = fe;
    @(negedge clk);
    line_push = '0; line_perr = '0; line_ferr = '0;
  endtask

  task automatic pop_cmp(input string req);
    logic [15:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    check(req, rx_word, e);
  endtask

  task automatic set_alarm(input int v);
    alarm_we = 1'b1; alarm_wdata = 7'(v);
    @(negedge clk);
    alarm_we = 1'b0;
  endtask

  task automatic set_ie(input logic b);
    csr_we = 1'b1; csr_wdata = '0; csr_wdata[6] = b;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; line_push = '0; line_char = '0; line_perr = '0; line_ferr = '0;
    rx_pop = 1'b0; csr_we = 1'b0; csr_wdata = '0; alarm_we = 1'b0; alarm_wdata = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 word", rx_word, 16'h0000);
    check("R1 csr", csr_rdata, 16'h0000);
    check("R1 irq", {15'b0, rx_irq}, 16'h0000);
    check("R1 alarm", {9'b0, alarm_rdata}, 16'h0001);

    // R2 field layout and order
    push1(3, 8'h41, 1'b1, 1'b0); exp_q.push_back(mk(3, 8'h41, 1, 0, 0));
    cyc(1);
    push1(10, 8'h00, 1'b0, 1'b1); exp_q.push_back(mk(10, 8'h00, 0, 1, 0));
    cyc(2);
    pop_cmp("R2 first");
    check("R2 hold", rx_word, 16'h9341);
    cyc(1);
    check("R2 stable", rx_word, 16'h9341);
    pop_cmp("R2 second");
    // R3 empty pop
    pop_cmp("R3 empty");

    // R4 simultaneous pushes, lowest first
    line_push = 16'h1084;
    line_char[7*8 +: 8] = 8'h70; line_char[2*8 +: 8] = 8'h20; line_char[12*8 +: 8] = 8'hC0;
    @(negedge clk);
    line_push = '0;
    exp_q.push_back(mk(2, 8'h20, 0, 0, 0));
    exp_q.push_back(mk(7, 8'h70, 0, 0, 0));
    exp_q.push_back(mk(12, 8'hC0, 0, 0, 0));
    cyc(4);
    pop_cmp("R4 line2"); pop_cmp("R4 line7"); pop_cmp("R4 line12");

    // R5 overrun at the holding slot
    line_push = 16'h0021;
    line_char[0 +: 8] = 8'h78; line_char[5*8 +: 8] = 8'h61;
    @(negedge clk);
    line_push = 16'h0020; line_char[5*8 +: 8] = 8'h62;
    @(negedge clk);
    line_push = '0;
    exp_q.push_back(mk(0, 8'h78, 0, 0, 0));
    exp_q.push_back(mk(5, 8'h61, 0, 0, 1));
    cyc(3);
    push1(5, 8'h63, 1'b0, 1'b0); exp_q.push_back(mk(5, 8'h63, 0, 0, 0));
    cyc(2);
    pop_cmp("R5 other line"); pop_cmp("R5 flagged"); pop_cmp("R5 cleared");

    // R8 / R9 / R10 alarm, flag and interrupt
    set_alarm(3);
    check("R10 readback", {9'b0, alarm_rdata}, 16'h0003);
    set_ie(1'b1);
    check("R9 enable readback", csr_rdata, 16'h0040);
    line_push = 16'h0016;
    line_char[1*8 +: 8] = 8'h11; line_char[2*8 +: 8] = 8'h22; line_char[4*8 +: 8] = 8'h44;
    @(negedge clk);
    line_push = '0;
    exp_q.push_back(mk(1, 8'h11, 0, 0, 0));
    exp_q.push_back(mk(2, 8'h22, 0, 0, 0));
    exp_q.push_back(mk(4, 8'h44, 0, 0, 0));
    cyc(3);
    check("R8 below alarm", csr_rdata, 16'h0040);
    check("R9 no irq below", {15'b0, rx_irq}, 16'h0000);
    cyc(1);
    check("R8 at alarm", csr_rdata, 16'h00C0);
    check("R9 irq", {15'b0, rx_irq}, 16'h0001);
    pop_cmp("R8 pop");
    check("R8 flag lags", csr_rdata, 16'h00C0);
    cyc(1);
    check("R8 flag drop", csr_rdata, 16'h0040);
    check("R9 irq drop", {15'b0, rx_irq}, 16'h0000);
    set_ie(1'b0);
    push1(6, 8'h66, 1'b0, 1'b0); exp_q.push_back(mk(6, 8'h66, 0, 0, 0));
    cyc(2);
    check("R8 flag masked ie", csr_rdata, 16'h0080);
    check("R9 irq masked", {15'b0, rx_irq}, 16'h0000);
    set_alarm(1);
    pop_cmp("R2 drain a"); pop_cmp("R2 drain b"); pop_cmp("R2 drain c");
    pop_cmp("R3 empty again");

    // R6 full store
    set_alarm(64);
    for (int i = 0; i < 64; i++) begin
      push1(i % 16, 8'(i), 1'b0, 1'b0);
      exp_q.push_back(mk(i % 16, 8'(i), 0, 0, 0));
    end
    cyc(2);
    check("R6 full flag", csr_rdata, 16'h0080);
    push1(9, 8'hEE, 1'b0, 1'b0);
    cyc(2);
    pop_cmp("R6 first after full");
    cyc(1);
    check("R6 dropped not stored", csr_rdata, 16'h0000);
    push1(9, 8'h55, 1'b0, 1'b0); exp_q.push_back(mk(9, 8'h55, 0, 0, 1));
    cyc(2);
    check("R6 refilled", csr_rdata, 16'h0080);
    set_alarm(1);
    for (int i = 0; i < 64; i++) pop_cmp("R6 drain");
    pop_cmp("R6 empty after drain");

    // R7 pop and store in the same cycle
    push1(0, 8'hA0, 1'b0, 1'b0); exp_q.push_back(mk(0, 8'hA0, 0, 0, 0));
    cyc(1);
    push1(1, 8'hB1, 1'b0, 1'b0); exp_q.push_back(mk(1, 8'hB1, 0, 0, 0));
    cyc(2);
    line_push[2] = 1'b1; line_char[2*8 +: 8] = 8'hC2;
    @(negedge clk);
    line_push = '0;
    exp_q.push_back(mk(2, 8'hC2, 0, 0, 0));
    pop_cmp("R7 pop with store");
    cyc(2);
    pop_cmp("R7 second"); pop_cmp("R7 stored"); pop_cmp("R7 empty");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule